// File: doc/BRIEF.md
# Modem Status Register with Change Flags

This block is the modem-status part of one UART channel. It watches four active-low handshake pins from an attached modem or peripheral: clear-to-send, data-set-ready, ring indicator and carrier detect. Each pin passes through a two-stage synchronizer. The block then shows the active-high level of each line in the upper half of an 8-bit status byte. The lower half holds four sticky flags that record line changes since the last time the CPU read the byte. Any set flag raises a modem-status interrupt request.

When the channel runs in loop-back test mode, the four status levels are taken from the channel's own modem-control outputs instead of the pins. These are request-to-send, data-terminal-ready and two general-purpose outputs. Changes on these outputs set the change flags in the same way that pin changes do.

The block also drives a flow-control gate for the transmitter. When automatic CTS flow control is enabled and the CTS level is inactive, the gate tells the transmitter not to start another character. The transmitter samples the gate only between characters, so a character already being shifted out is always completed.

Top module: `mdm_status_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `status_q` reads 0x00 and `irq` is low.
- R2: Outside loop-back mode, the status levels are the complement of the pins, in this layout: bit 7 = carrier detect, bit 6 = ring, bit 5 = data-set-ready, bit 4 = clear-to-send. A pin change becomes visible on the third rising clock edge after it is applied (two synchronizer flops, then the status register).
- R3: In loop-back mode, bit 7 follows `ctl_aux2`, bit 6 follows `ctl_aux1`, bit 5 follows `ctl_dtr` and bit 4 follows `ctl_rts`, one clock edge after they are applied. The pins have no effect on the status byte.
- R4: Bit 3 (carrier), bit 1 (data-set-ready) and bit 0 (clear-to-send) are set on the same edge that their status level (bit 7, 5 or 4) changes in either direction.
- R5: Bit 2 is set only when status bit 6 falls from 1 to 0, which means the ring pin has gone from low to high. A rise of bit 6 does not set bit 2.
- R6: A set change flag stays set until a clock edge at which `rd_stb` is high. That edge clears all four flags.
- R7: If a flag's change event happens on the same edge as a read, that flag ends up set rather than cleared.
- R8: `irq` is high exactly when at least one of status bits 3..0 is set.
- R9: `tx_may_start` is low when `flow_en` is high and status bit 4 is 0. In every other case it is high.
- R10: In loop-back mode, changes on the modem-control outputs set the change flags under the rules of R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| pin_ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| pin_cd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| loop_en | input | 1 | Loop-back test mode select |
| ctl_rts | input | 1 | Request-to-send control output bit |
| ctl_dtr | input | 1 | Data-terminal-ready control output bit |
| ctl_aux1 | input | 1 | General-purpose control output 1 |
| ctl_aux2 | input | 1 | General-purpose control output 2 |
| flow_en | input | 1 | Enables automatic CTS flow control |
| rd_stb | input | 1 | CPU read of the status byte; clears the flags at this edge |
| status_q | output | 8 | Line levels in bits 7..4, change flags in bits 3..0 |
| irq | output | 1 | Modem-status interrupt request |
| tx_may_start | output | 1 | Transmitter may begin its next character |

## Verification
The assertions check the following on every cycle:
- Each pin's level arrives after exactly three edges in normal mode.
- The control bits are mirrored one edge later in loop-back mode.
- A level change is never present without its flag.
- Flags persist across cycles without a read.
- A read with unchanged levels leaves all flags clear.
- Ring flags are raised only by a fall of bit 6.
- The interrupt and flow gate agree with the status byte.

Some behaviours need the bench's scenarios to show them. These are:
- A change that lands exactly on the read edge and so survives it.
- Spurious flags raised when loop-back mode is switched while pins and control bits disagree.
- Pin activity being ignored for the whole time loop-back mode is on.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  // Number of modem handshake lines tracked per channel.
  localparam int unsigned LINES = 4;

  // Line index within a line vector. A flag sits at the same index in
  // the lower nibble, and the level at index + LINES in the upper one.
  localparam int unsigned IDX_CTS = 0;
  localparam int unsigned IDX_DSR = 1;
  localparam int unsigned IDX_RI  = 2;
  localparam int unsigned IDX_CD  = 3;

  localparam int unsigned STATUS_W = 2 * LINES;

  typedef logic [LINES-1:0]    line_vec_t;
  typedef logic [STATUS_W-1:0] status_t;

  // Which kind of level change arms a change flag.
  typedef enum logic {
    EDGE_ANY  = 1'b0,
    EDGE_FALL = 1'b1
  } edge_kind_e;

endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  // Next-state: stage 0 samples the asynchronous inputs, and every
  // later stage takes the value of the stage before it.
  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= RST_VAL;
      end
    end else begin
      for (int i = 0; i < STAGES; i++) begin
        stg_q[i] <= stg_d[i];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/mdm_delta_flag.sv
module mdm_delta_flag
  import mdm_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_ANY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_prev,
  input  logic lvl_next,
  input  logic rd_clr,
  output logic flag_q
);

  logic evt;
  logic flag_d;
  logic flag_en;

  // Pick the change detector that this line's flag uses.
  generate
    if (KIND == EDGE_FALL) begin : g_fall
      assign evt = lvl_prev & ~lvl_next;
    end else begin : g_any
      assign evt = lvl_prev ^ lvl_next;
    end
  endgenerate

  // A new event takes priority over a read-clear on the same edge.
  always_comb begin
    flag_en = evt | rd_clr;
    flag_d  = evt;
    if (!evt && !rd_clr) begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/mdm_flow_gate.sv
module mdm_flow_gate (
  input  logic flow_en,
  input  logic cts_lvl,
  output logic may_start
);

  // With flow control off the transmitter is never held back. With it
  // on, an inactive CTS level blocks the start of the next character.
  always_comb begin
    may_start = 1'b1;
    if (flow_en && !cts_lvl) begin
      may_start = 1'b0;
    end
  end

endmodule

// File: rtl/mdm_status_unit.sv
module mdm_status_unit
  import mdm_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_cts_n,
  input  logic       pin_dsr_n,
  input  logic       pin_ri_n,
  input  logic       pin_cd_n,
  input  logic       loop_en,
  input  logic       ctl_rts,
  input  logic       ctl_dtr,
  input  logic       ctl_aux1,
  input  logic       ctl_aux2,
  input  logic       flow_en,
  input  logic       rd_stb,
  output logic [7:0] status_q,
  output logic       irq,
  output logic       tx_may_start
);

  line_vec_t pin_raw_n;
  line_vec_t pin_sync_n;
  line_vec_t loop_src;
  line_vec_t lvl_next;
  line_vec_t lvl_q;
  line_vec_t flag_q;
  logic      lvl_en;

  // Gather the pins in line-index order.
  always_comb begin
    pin_raw_n          = '1;
    pin_raw_n[IDX_CTS] = pin_cts_n;
    pin_raw_n[IDX_DSR] = pin_dsr_n;
    pin_raw_n[IDX_RI]  = pin_ri_n;
    pin_raw_n[IDX_CD]  = pin_cd_n;
  end

  // The reset value of all ones means every line starts inactive.
  mdm_sync #(
    .W       (LINES),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({LINES{1'b1}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_raw_n),
    .q     (pin_sync_n)
  );

  // Loop-back routing from the modem-control outputs to the lines.
  always_comb begin
    loop_src          = '0;
    loop_src[IDX_CTS] = ctl_rts;
    loop_src[IDX_DSR] = ctl_dtr;
    loop_src[IDX_RI]  = ctl_aux1;
    loop_src[IDX_CD]  = ctl_aux2;
  end

  // Pick the level source for each line.
  always_comb begin
    if (loop_en) begin
      lvl_next = loop_src;
    end else begin
      lvl_next = ~pin_sync_n;
    end
    lvl_en = (lvl_next != lvl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (lvl_en) begin
      lvl_q <= lvl_next;
    end
  end

  // One change flag per line. The ring line reacts only to a falling
  // level; every other line reacts to any change.
  generate
    for (genvar i = 0; i < LINES; i++) begin : g_flag
      localparam edge_kind_e KIND_I = (i == IDX_RI) ? EDGE_FALL : EDGE_ANY;
      mdm_delta_flag #(
        .KIND (KIND_I)
      ) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_prev (lvl_q[i]),
        .lvl_next (lvl_next[i]),
        .rd_clr   (rd_stb),
        .flag_q   (flag_q[i])
      );
    end
  endgenerate

  mdm_flow_gate u_gate (
    .flow_en   (flow_en),
    .cts_lvl   (lvl_q[IDX_CTS]),
    .may_start (tx_may_start)
  );

  assign status_q = {lvl_q, flag_q};
  assign irq      = |flag_q;

endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_cts_n,
  input logic       pin_dsr_n,
  input logic       pin_ri_n,
  input logic       pin_cd_n,
  input logic       loop_en,
  input logic       ctl_rts,
  input logic       ctl_dtr,
  input logic       ctl_aux1,
  input logic       ctl_aux2,
  input logic       flow_en,
  input logic       rd_stb,
  input logic [7:0] status_q,
  input logic       irq,
  input logic       tx_may_start
);

  // Counts edges since reset, so that a pin history reaching back
  // into reset is never compared.
  logic [2:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != 3'd4) begin
      age_q <= age_q + 3'd1;
    end
  end

  // R2: in normal mode the levels trail the pins by three edges.
  assert_pin_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd4 && $past(!loop_en)) |->
      status_q[7:4] == ~$past({pin_cd_n, pin_ri_n, pin_dsr_n, pin_cts_n}, 3));

  // R3: in loop-back mode the levels mirror the control bits one edge later.
  assert_loop_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loop_en) |->
      status_q[7:4] == $past({ctl_aux2, ctl_aux1, ctl_dtr, ctl_rts}));

  // R4 / R10: a level change on CD, DSR or CTS always raises its flag.
  assert_change_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q[7:4] ^ $past(status_q[7:4])) & 4'b1011 & ~status_q[3:0]) == 4'b0000);

  // R5: a falling ring level always raises the ring flag.
  assert_ri_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_q[6]) |-> status_q[2]);

  // R5: a rising ring level at a read edge leaves the ring flag clear.
  assert_ri_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status_q[6]) && $past(rd_stb)) |-> !status_q[2]);

  // R6: without a read, no set flag is lost.
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((status_q[3:0] & $past(status_q[3:0])) == $past(status_q[3:0])));

  // R6: a read across which no level moved leaves every flag clear.
  assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_stb) && $stable(status_q[7:4])) |-> status_q[3:0] == 4'b0000);

  // R8: the interrupt request matches the flag nibble.
  assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (status_q[3:0] != 4'b0000));

  // R9: the flow gate blocks only when enabled with CTS inactive.
  assert_gate_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_en && !status_q[4]) |-> !tx_may_start);

  assert_gate_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_en || status_q[4]) |-> tx_may_start);

endmodule

bind mdm_status_unit mdm_status_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pin_cts_n    (pin_cts_n),
  .pin_dsr_n    (pin_dsr_n),
  .pin_ri_n     (pin_ri_n),
  .pin_cd_n     (pin_cd_n),
  .loop_en      (loop_en),
  .ctl_rts      (ctl_rts),
  .ctl_dtr      (ctl_dtr),
  .ctl_aux1     (ctl_aux1),
  .ctl_aux2     (ctl_aux2),
  .flow_en      (flow_en),
  .rd_stb       (rd_stb),
  .status_q     (status_q),
  .irq          (irq),
  .tx_may_start (tx_may_start)
);

// File: tb/mdm_status_unit_tb.sv
`timescale 1ns/1ps
module mdm_status_unit_tb;

  logic       clk;
  logic       rst_n;
  logic       pin_cts_n, pin_dsr_n, pin_ri_n, pin_cd_n;
  logic       loop_en;
  logic       ctl_rts, ctl_dtr, ctl_aux1, ctl_aux2;
  logic       flow_en;
  logic       rd_stb;
  logic [7:0] status_q;
  logic       irq;
  logic       tx_may_start;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference state, built from the requirements alone.
  logic [3:0] s1_m, s2_m, lvl_m, flg_m;

  mdm_status_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .pin_cts_n(pin_cts_n), .pin_dsr_n(pin_dsr_n),
    .pin_ri_n(pin_ri_n), .pin_cd_n(pin_cd_n),
    .loop_en(loop_en), .ctl_rts(ctl_rts), .ctl_dtr(ctl_dtr),
    .ctl_aux1(ctl_aux1), .ctl_aux2(ctl_aux2),
    .flow_en(flow_en), .rd_stb(rd_stb),
    .status_q(status_q), .irq(irq), .tx_may_start(tx_may_start)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pins_vec();
    return {pin_cd_n, pin_ri_n, pin_dsr_n, pin_cts_n};
  endfunction

  function automatic logic [3:0] ctl_vec();
    return {ctl_aux2, ctl_aux1, ctl_dtr, ctl_rts};
  endfunction

  task automatic model_reset();
    s1_m = 4'hF; s2_m = 4'hF; lvl_m = 4'h0; flg_m = 4'h0;
  endtask

  // Advances the reference by one clock edge, using the inputs that
  // were applied across that edge.
  task automatic model_step();
    logic [3:0] nxt, ev;
    nxt   = loop_en ? ctl_vec() : ~s2_m;
    ev    = nxt ^ lvl_m;
    ev[2] = lvl_m[2] & ~nxt[2];
    flg_m = ev | (flg_m & ~{4{rd_stb}});
    lvl_m = nxt;
    s2_m  = s1_m;
    s1_m  = pins_vec();
  endtask

  task automatic compare_all();
    chk(loop_en ? "R3 levels" : "R2 levels", {4'h0, status_q[7:4]}, {4'h0, lvl_m});
    chk("R4 flags", {4'h0, status_q[3], 1'b0, status_q[1:0]}, {4'h0, flg_m[3], 1'b0, flg_m[1:0]});
    chk("R5 ring flag", {7'h0, status_q[2]}, {7'h0, flg_m[2]});
    chk("R8 irq", {7'h0, irq}, {7'h0, |flg_m});
    chk("R9 gate", {7'h0, tx_may_start}, {7'h0, !flow_en || lvl_m[0]});
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_step();
    compare_all();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0;
    {pin_cts_n, pin_dsr_n, pin_ri_n, pin_cd_n} = 4'hF;
    {loop_en, ctl_rts, ctl_dtr, ctl_aux1, ctl_aux2, flow_en, rd_stb} = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset status", status_q, 8'h00);
    chk("R1 reset irq", {7'h0, irq}, 8'h00);
    rst_n = 1'b1;
    tick();
    chk("R1 first cycle", status_q, 8'h00);

    // R2 / R4: carrier asserted, seen after three edges.
    pin_cd_n = 1'b0;
    ticks(2);
    chk("R2 not yet", {7'h0, status_q[7]}, 8'h00);
    tick();
    chk("R2 cd level", status_q, 8'h88);
    chk("R8 irq on", {7'h0, irq}, 8'h01);

    // R6: flags persist, then the read clears them.
    ticks(3);
    chk("R6 sticky", status_q, 8'h88);
    rd_stb = 1'b1; tick(); rd_stb = 1'b0;
    chk("R6 read clear", status_q, 8'h80);

    // R5: the ring rising does not flag; the ring falling does.
    pin_ri_n = 1'b0; ticks(3);
    chk("R5 ring rise", status_q, 8'hC0);
    pin_ri_n = 1'b1; ticks(3);
    chk("R5 ring fall", status_q, 8'h84);
    rd_stb = 1'b1; tick(); rd_stb = 1'b0;

    // R7: DSR change lands exactly on the read edge.
    pin_dsr_n = 1'b0; ticks(2);
    rd_stb = 1'b1; tick(); rd_stb = 1'b0;
    chk("R7 event at read", status_q, 8'hA2);
    rd_stb = 1'b1; tick(); rd_stb = 1'b0;

    // R9: flow control blocks while CTS is inactive.
    flow_en = 1'b1; tick();
    chk("R9 blocked", {7'h0, tx_may_start}, 8'h00);
    pin_cts_n = 1'b0; ticks(3);
    chk("R9 open", {7'h0, tx_may_start}, 8'h01);
    flow_en = 1'b0;
    rd_stb = 1'b1; tick(); rd_stb = 1'b0;

    // R3 / R10: loop-back mirrors the control bits and ignores the pins.
    {ctl_aux2, ctl_aux1, ctl_dtr, ctl_rts} = 4'b1011;
    loop_en = 1'b1; tick();
    rd_stb = 1'b1; tick(); rd_stb = 1'b0;
    chk("R3 loop map", status_q, 8'hB0);
    {pin_cts_n, pin_dsr_n, pin_ri_n, pin_cd_n} = 4'h0; ticks(4);
    chk("R3 pins ignored", status_q, 8'hB0);
    ctl_aux1 = 1'b1; tick(); ctl_aux1 = 1'b0; tick();
    chk("R10 loop ring fall", status_q, 8'hB4);
    ctl_rts = 1'b0; tick();
    chk("R10 loop rts change", status_q, 8'hA5);
    loop_en = 1'b0;
    rd_stb = 1'b1; ticks(4); rd_stb = 1'b0;

    // Random phase against the reference model.
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 5) == 0) pin_cts_n = ~pin_cts_n;
      if (($urandom % 7) == 0) pin_dsr_n = ~pin_dsr_n;
      if (($urandom % 6) == 0) pin_ri_n  = ~pin_ri_n;
      if (($urandom % 9) == 0) pin_cd_n  = ~pin_cd_n;
      if (($urandom % 4) == 0) {ctl_aux2, ctl_aux1, ctl_dtr, ctl_rts} = 4'($urandom);
      if (($urandom % 64) == 0) loop_en = ~loop_en;
      if (($urandom % 32) == 0) flow_en = ~flow_en;
      rd_stb = (($urandom % 8) == 0);
      tick();
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule